// File: doc/BRIEF.md
# SPI Receive Frame Buffer with Overflow Policy

This block sits behind an SPI shift register and queues the frames it completes, so that software can collect them later through a pop read. Each completed frame is put into a four-entry circular store. A read strobe takes out the oldest entry and presents it on a registered data output. The block reports how many entries are waiting and which storage slot the next pop read will return.

If a frame completes while the store is full, it stays in a single holding stage that stands for the shift register. That stage empties into the store in the first cycle in which a slot is free. A transfer that begins while both the store and the holding stage are occupied raises a sticky overflow flag. A mode input then chooses what happens to that transfer's frame: it can replace the held frame or be thrown away. A flush input empties everything in one cycle. Serial shifting, clock generation and register decoding are handled elsewhere; frame completion and transfer start reach the block as single-cycle strobes.

Top module: `spi_rx_buffer`

## Requirements
- R1: After reset the level output is 0, the next-index output is 0, the overflow flag is 0 and the pop data is 0. A `frame_done_i` strobe while the level is below 4 and the holding stage is empty stores `frame_data_i`, and the level rises by one at the next clock edge.
- R2: A `pop_i` strobe while the level is non-zero puts the oldest stored frame on `pop_data_o` at the next edge and lowers the level by one. Frames leave in the order they arrived.
- R3: A `pop_i` strobe while the level is 0 changes no state: level, next index and `pop_data_o` all keep their values.
- R4: `next_idx_o` is a 2-bit slot index. It advances by one on every pop that takes out a frame and wraps from 3 to 0.
- R5: A frame that completes while the level is 4 goes into the holding stage. The holding stage empties into the store at the first edge at which the level seen before that edge is below 4. The level then rises by one at that edge.
- R6: A `xfer_start_i` strobe while the level is 4 and the holding stage is occupied sets `ovf_o` at the next edge. The flag stays set until it is cleared.
- R7: A `ovf_clr_i` strobe clears `ovf_o` at the next edge. If a set condition occurs in the same cycle as a clear, the set wins.
- R8: With `ovwr_mode_i` = 1, a frame that completes while the level is 4 and the holding stage is occupied replaces the held frame.
- R9: With `ovwr_mode_i` = 0, that same frame is discarded and the held frame is kept.
- R10: A `flush_i` strobe sets the level to 0, the next index to 0 and the write position to 0, and empties the holding stage, all at the next edge. Any frame completion or pop in the same cycle is ignored. A flush does not change `ovf_o` or `pop_data_o`.
- R11: If the holding stage empties in a cycle in which another frame completes, the new frame takes the holding stage. If a pop and a frame completion happen in the same cycle on a full store, the frame goes to the holding stage and enters the store one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| frame_done_i | input | 1 | Strobe: a frame has completed in the shift register |
| frame_data_i | input | DATA_W | Frame content, valid with `frame_done_i` |
| xfer_start_i | input | 1 | Strobe: a new transfer begins |
| pop_i | input | 1 | Strobe: pop register read |
| flush_i | input | 1 | Strobe: empty the store and the holding stage |
| ovf_clr_i | input | 1 | Write-one-to-clear strobe for the overflow flag |
| ovwr_mode_i | input | 1 | 1: overflow data replaces the held frame; 0: it is discarded |
| pop_data_o | output | DATA_W | Last frame taken out by a pop |
| level_o | output | CNT_W | Number of stored frames, 0 to DEPTH |
| next_idx_o | output | PTR_W | Slot index the next pop will return |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The risky coincidence is a pop read in the same cycle as a frame completion on a full store. The same goes for a frame completion in the same cycle as the holding stage empties. In both cases the store sees two events, but it can accept only one write per cycle. The bench forces both cases on purpose: it fills the store, parks a frame in the holding stage, and then strobes pop and frame completion together, once with the held frame still waiting and once with a fresh frame arriving as the held one drains. A queue-based model predicts level, next index, pop data and flag after every edge. A later series of pops must return the frames in exactly the expected order, with none lost or duplicated.

// File: rtl/spi_rx_buffer_pkg.sv
package spi_rx_buffer_pkg;

  // Action taken on the holding stage in a cycle
  typedef enum logic [1:0] {
    HOLD_KEEP  = 2'd0,
    HOLD_LOAD  = 2'd1,
    HOLD_CLEAR = 2'd2
  } hold_act_e;

  function automatic int unsigned idx_bits(input int unsigned depth);
    return (depth <= 1) ? 1 : $clog2(depth);
  endfunction

endpackage

// File: rtl/spi_rx_rst_sync.sv
module spi_rx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/spi_rx_ptrs.sv
module spi_rx_ptrs #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PTR_W = 2,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic             pop,
  output logic             pop_ok,
  output logic             space,
  output logic [CNT_W-1:0] count,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] wr_ptr
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [CNT_W-1:0] count_q, count_d;
  logic [PTR_W-1:0] rd_q, rd_d;
  logic [PTR_W-1:0] wr_q, wr_d;
  logic             cnt_en, rd_en, wr_ptr_en;

  assign pop_ok = pop && (count_q != '0) && !flush;
  assign space  = (count_q != CNT_FULL);

  // next-state
  always_comb begin
    count_d   = count_q;
    rd_d      = rd_q;
    wr_d      = wr_q;
    cnt_en    = 1'b0;
    rd_en     = 1'b0;
    wr_ptr_en = 1'b0;
    if (flush) begin
      count_d   = '0;
      rd_d      = '0;
      wr_d      = '0;
      cnt_en    = 1'b1;
      rd_en     = 1'b1;
      wr_ptr_en = 1'b1;
    end else begin
      unique case ({wr_en, pop_ok})
        2'b10:   begin count_d = count_q + CNT_W'(1); cnt_en = 1'b1; end
        2'b01:   begin count_d = count_q - CNT_W'(1); cnt_en = 1'b1; end
        default: count_d = count_q;
      endcase
      if (pop_ok) begin
        rd_d  = (rd_q == PTR_LAST) ? '0 : rd_q + PTR_W'(1);
        rd_en = 1'b1;
      end
      if (wr_en) begin
        wr_d      = (wr_q == PTR_LAST) ? '0 : wr_q + PTR_W'(1);
        wr_ptr_en = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      rd_q    <= '0;
      wr_q    <= '0;
    end else begin
      if (cnt_en)    count_q <= count_d;
      if (rd_en)     rd_q    <= rd_d;
      if (wr_ptr_en) wr_q    <= wr_d;
    end
  end

  assign count  = count_q;
  assign rd_ptr = rd_q;
  assign wr_ptr = wr_q;

  // R1: level never exceeds depth
  p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_FULL);

  // R3: pop of an empty store leaves level and index untouched
  p_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count_q == '0 && !flush && !wr_en) |=> ($stable(count_q) && $stable(rd_q)));

  // R4: index advances by one slot per effective pop, with wrap
  p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count_q != '0 && !flush) |=>
      (rd_q == (($past(rd_q) == PTR_LAST) ? '0 : $past(rd_q) + PTR_W'(1))));

  // R10: flush returns level and pointers to zero
  p_flush_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count_q == '0 && rd_q == '0 && wr_q == '0));

endmodule

// File: rtl/spi_rx_hold.sv
module spi_rx_hold
  import spi_rx_buffer_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              space,
  input  logic              ovwr_mode,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              hold_vld
);

  logic              vld_q;
  logic [DATA_W-1:0] data_q;
  hold_act_e         act;

  // buffer write: held frame has precedence over a fresh one
  always_comb begin
    wr_en   = 1'b0;
    wr_data = frame_data;
    if (!flush) begin
      if (vld_q) begin
        wr_en   = space;
        wr_data = data_q;
      end else begin
        wr_en   = frame_done && space;
        wr_data = frame_data;
      end
    end
  end

  // next-state action
  always_comb begin
    act = HOLD_KEEP;
    if (flush) begin
      act = HOLD_CLEAR;
    end else if (vld_q) begin
      if (space) begin
        act = frame_done ? HOLD_LOAD : HOLD_CLEAR;
      end else if (frame_done && ovwr_mode) begin
        act = HOLD_LOAD;
      end
    end else if (frame_done && !space) begin
      act = HOLD_LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      unique case (act)
        HOLD_LOAD: begin
          vld_q  <= 1'b1;
          data_q <= frame_data;
        end
        HOLD_CLEAR: vld_q <= 1'b0;
        default:    vld_q <= vld_q;
      endcase
    end
  end

  assign hold_vld = vld_q;

  // R5: a frame completing into a full store is retained
  p_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !space && !flush && !vld_q) |=> vld_q);

  // R8: overwrite mode replaces the held frame
  p_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !space && frame_done && ovwr_mode && !flush) |=> (data_q == $past(frame_data)));

  // R9: discard mode keeps the held frame
  p_discard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !space && frame_done && !ovwr_mode && !flush) |=> ($stable(data_q) && vld_q));

  // R11: held frame drains while a fresh frame replaces it
  p_drain_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && space && frame_done && !flush) |=> (vld_q && data_q == $past(frame_data)));

endmodule

// File: rtl/spi_rx_store.sv
module spi_rx_store #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned PTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (wr_ptr == PTR_W'(gi));
    always_ff @(posedge clk) begin
      if (slot_we) slot_q[gi] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= slot_q[rd_ptr];
    end
  end

  assign rd_data = rd_q;

  // R3: output only moves on an effective pop
  p_data_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_q));

endmodule

// File: rtl/spi_rx_ovf.sv
module spi_rx_ovf (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_start,
  input  logic store_full,
  input  logic hold_vld,
  input  logic clr,
  output logic ovf
);

  logic ovf_q, ovf_d, set_c;

  assign set_c = xfer_start && store_full && hold_vld;

  always_comb begin
    ovf_d = ovf_q;
    if (set_c)    ovf_d = 1'b1;
    else if (clr) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign ovf = ovf_q;

  // R6: sticky until cleared
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr) |=> ovf_q);

  // R7: set beats a same-cycle clear
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && store_full && hold_vld) |=> ovf_q);

  // R7: clear without set drops the flag
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(xfer_start && store_full && hold_vld)) |=> !ovf_q);

endmodule

// File: rtl/spi_rx_buffer.sv
module spi_rx_buffer
  import spi_rx_buffer_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W = idx_bits(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done_i,
  input  logic [DATA_W-1:0] frame_data_i,
  input  logic              xfer_start_i,
  input  logic              pop_i,
  input  logic              flush_i,
  input  logic              ovf_clr_i,
  input  logic              ovwr_mode_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic [CNT_W-1:0]  level_o,
  output logic [PTR_W-1:0]  next_idx_o,
  output logic              ovf_o
);

  logic             rst_int_n;
  logic             wr_en, pop_ok, space, hold_vld;
  logic [DATA_W-1:0] wr_data;
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;

  spi_rx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  spi_rx_ptrs #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptrs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .flush  (flush_i),
    .wr_en  (wr_en),
    .pop    (pop_i),
    .pop_ok (pop_ok),
    .space  (space),
    .count  (count),
    .rd_ptr (rd_ptr),
    .wr_ptr (wr_ptr)
  );

  spi_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .flush      (flush_i),
    .frame_done (frame_done_i),
    .frame_data (frame_data_i),
    .space      (space),
    .ovwr_mode  (ovwr_mode_i),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .hold_vld   (hold_vld)
  );

  spi_rx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_ptr  (wr_ptr),
    .wr_data (wr_data),
    .rd_en   (pop_ok),
    .rd_ptr  (rd_ptr),
    .rd_data (pop_data_o)
  );

  spi_rx_ovf u_ovf (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .xfer_start (xfer_start_i),
    .store_full (!space),
    .hold_vld   (hold_vld),
    .clr        (ovf_clr_i),
    .ovf        (ovf_o)
  );

  assign level_o    = count;
  assign next_idx_o = rd_ptr;

  // R2: an effective pop without a write lowers the level by one
  p_pop_level_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pop_i && level_o != '0 && !flush_i && !wr_en) |=> (level_o == $past(level_o) - CNT_W'(1)));

  // R10: flush leaves the flag alone
  p_flush_flag_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flush_i && !ovf_clr_i && !xfer_start_i) |=> (ovf_o == $past(ovf_o)));

endmodule

// File: tb/spi_rx_buffer_test.sv
module spi_rx_buffer_test;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_done_i = 1'b0;
  logic [DW-1:0] frame_data_i = '0;
  logic          xfer_start_i = 1'b0;
  logic          pop_i = 1'b0;
  logic          flush_i = 1'b0;
  logic          ovf_clr_i = 1'b0;
  logic          ovwr_mode_i = 1'b0;
  logic [DW-1:0] pop_data_o;
  logic [2:0]    level_o;
  logic [1:0]    next_idx_o;
  logic          ovf_o;

  spi_rx_buffer uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_done_i (frame_done_i),
    .frame_data_i (frame_data_i),
    .xfer_start_i (xfer_start_i),
    .pop_i        (pop_i),
    .flush_i      (flush_i),
    .ovf_clr_i    (ovf_clr_i),
    .ovwr_mode_i  (ovwr_mode_i),
    .pop_data_o   (pop_data_o),
    .level_o      (level_o),
    .next_idx_o   (next_idx_o),
    .ovf_o        (ovf_o)
  );

  always #5 clk = ~clk;

  // reference model state
  logic [DW-1:0] mq[$];
  int            m_idx = 0;
  bit            m_hv = 0;
  logic [DW-1:0] m_hd = '0;
  bit            m_ovf = 0;
  logic [DW-1:0] m_pd = '0;

  int    vectors = 0;
  int    errors  = 0;
  bit    done    = 0;
  string cur_req = "R1";

  task automatic model_step();
    int  sz;
    bit  hv;
    bit  room;
    sz   = mq.size();
    hv   = m_hv;
    room = (sz < 4);
    if (xfer_start_i && sz == 4 && hv) m_ovf = 1;
    else if (ovf_clr_i)                m_ovf = 0;
    if (flush_i) begin
      mq.delete();
      m_idx = 0;
      m_hv  = 0;
    end else begin
      if (pop_i && sz > 0) begin
        m_pd  = mq.pop_front();
        m_idx = (m_idx + 1) % 4;
      end
      if (hv && room) begin
        mq.push_back(m_hd);
        if (frame_done_i) m_hd = frame_data_i;
        else              m_hv = 0;
      end else if (!hv && frame_done_i) begin
        if (room) mq.push_back(frame_data_i);
        else begin
          m_hv = 1;
          m_hd = frame_data_i;
        end
      end else if (hv && frame_done_i && ovwr_mode_i) begin
        m_hd = frame_data_i;
      end
    end
  endtask

  task automatic compare();
    bit bad;
    bad = 0;
    vectors++;
    if (level_o !== 3'(mq.size())) begin
      $display("FAIL %s level: got %0d exp %0d", cur_req, level_o, mq.size());
      bad = 1;
    end
    if (next_idx_o !== 2'(m_idx)) begin
      $display("FAIL %s next_idx: got %0d exp %0d", cur_req, next_idx_o, m_idx);
      bad = 1;
    end
    if (pop_data_o !== m_pd) begin
      $display("FAIL %s pop_data: got %h exp %h", cur_req, pop_data_o, m_pd);
      bad = 1;
    end
    if (ovf_o !== m_ovf) begin
      $display("FAIL %s ovf: got %0d exp %0d", cur_req, ovf_o, m_ovf);
      bad = 1;
    end
    if (bad) errors++;
  endtask

  // one clock with the given strobes; called at a falling edge
  task automatic tick(input bit fd, input logic [DW-1:0] d, input bit xs,
                      input bit pp, input bit fl, input bit cl);
    frame_done_i = fd;
    frame_data_i = d;
    xfer_start_i = xs;
    pop_i        = pp;
    flush_i      = fl;
    ovf_clr_i    = cl;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    frame_done_i = 0;
    xfer_start_i = 0;
    pop_i        = 0;
    flush_i      = 0;
    ovf_clr_i    = 0;
  endtask

  task automatic push(input logic [DW-1:0] d);
    tick(1, d, 0, 0, 0, 0);
  endtask

  task automatic popr();
    tick(0, '0, 0, 1, 0, 0);
  endtask

  task automatic idle();
    tick(0, '0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cur_req = "R1";
    compare();                                   // reset state
    push(16'h1111); push(16'h2222); push(16'h3333);

    cur_req = "R2";
    popr(); popr();

    cur_req = "R3";
    popr(); popr(); popr();                       // last two on empty

    cur_req = "R4";
    for (int i = 0; i < 6; i++) begin
      push(16'h4000 + 16'(i));
      popr();
    end

    cur_req = "R5";
    tick(1, '0, 0, 0, 1, 0);                      // flush, frame ignored
    for (int i = 0; i < 4; i++) push(16'h5000 + 16'(i));
    push(16'h5AAA);                               // parked
    idle();
    popr();                                       // slot frees
    idle();                                       // held frame drains

    cur_req = "R6";
    push(16'h6BBB);                               // parked again
    tick(0, '0, 1, 0, 0, 0);                      // start on full -> flag
    idle(); idle();

    cur_req = "R7";
    tick(0, '0, 0, 0, 0, 1);                      // clear
    tick(0, '0, 1, 0, 0, 1);                      // set and clear together
    tick(0, '0, 0, 0, 0, 1);

    cur_req = "R8";
    ovwr_mode_i = 1'b1;
    tick(1, 16'h8CCC, 1, 0, 0, 0);
    for (int i = 0; i < 5; i++) popr();

    cur_req = "R9";
    ovwr_mode_i = 1'b0;
    for (int i = 0; i < 4; i++) push(16'h9000 + 16'(i));
    push(16'h9DDD);
    tick(1, 16'h9EEE, 1, 0, 0, 0);                // discarded
    for (int i = 0; i < 6; i++) popr();

    cur_req = "R10";
    push(16'hA001); push(16'hA002); popr();
    tick(1, 16'hA0FF, 0, 1, 1, 0);                // flush wins over pop and frame
    popr();
    tick(0, '0, 0, 0, 0, 1);

    cur_req = "R11";
    for (int i = 0; i < 4; i++) push(16'hB000 + 16'(i));
    tick(1, 16'hB0AA, 0, 1, 0, 0);                // pop + frame on full store
    tick(1, 16'hB0BB, 0, 0, 0, 0);                // drain + fresh frame
    idle();
    for (int i = 0; i < 7; i++) popr();

    cur_req = "R11";
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 99);
      ovwr_mode_i = r[0];
      tick(r < 55, 16'($urandom), r[1] & r[2], (r % 3) == 0, r == 97, r[3] & r[4] & r[5]);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule